// File: doc/BRIEF.md
# Iterative Soft-In Soft-Out Product Code Decoder (8x8, one half-iteration per clock)

This block decodes one received 8x8 array of 5-bit soft samples. The array is protected by a two-dimensional product code. Every row and every column of a valid array is a word of an (8,4,4) component code. The component code splits each 8-bit word into four bit pairs. Either every pair is taken from {00, 11} or every pair is taken from {01, 10}, and the four pair selectors must have even parity.

Eight row decoders work in parallel, so one half-iteration (decoding all eight rows) takes a single clock. A register buffer holds the received array and the scaled extrinsic array between steps. Each step transposes both arrays, which makes rows and columns alternate.

The soft output of a decoder is a fixed ±β. β grows with the step number. The extrinsic information is the soft output minus the decoder input, scaled by one quarter. After 2·ITERS steps the block raises `done` and presents the 64 hard decisions in the orientation of the original array. A host pulses `start` with the samples on `rx_soft` and waits for `done`.

Top module: `tpd_iter_top`

## Requirements
- R1: A `start` pulse while idle captures `rx_soft` and zeroes the extrinsic array. Element (row r, column c) is the two's-complement value in bits [(8r+c)*5 +: 5]. The first step decodes the rows of the captured array.
- R2: The block performs one step per clock. `done` rises exactly 2·ITERS clock edges after the edge that sampled `start`.
- R3: Each row decoder returns the component codeword of least total metric. A decision 1 costs 15−e and a decision 0 costs e+16. Per pair, the first bit is the pair selector s and the second bit is s for the {00,11} family and ~s for the {01,10} family. Selector 1 is taken only if it is strictly cheaper. If the selector parity is odd, the pair with the smallest cost difference is flipped, with the lowest index winning a tie. The {00,11} family wins a tie between families.
- R4: The soft output is +β for a decision 1 and −β for a decision 0, where β(j) = min(4j−1, 15) for step j = 1..2·ITERS.
- R5: The extrinsic value is the soft output minus the decoder input, divided by 4 and rounded toward minus infinity. It feeds the next step transposed. The next decoder input is the transposed received array plus that value, clamped to [−16, +15].
- R6: Bit 8r+c of `hard_bits` is the decision for row r, column c of the original array, with 1 meaning a positive sample. This holds whatever the parity of the step count.
- R7: A valid product codeword sent as ±12 with no noise decodes to exactly that codeword.
- R8: A `start` pulse while a decode is running is ignored. It changes neither the result nor the completion time, including when it coincides with the last step.
- R9: `done` falls on the edge after an accepted `start`. Once high, `done` and `hard_bits` hold until the next accepted `start`.
- R10: During and right after reset, `done` is 0 and `hard_bits` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a decode of `rx_soft` when idle |
| rx_soft | input | 320 | 64 signed 5-bit received samples, row-major |
| done | output | 1 | High once the final step has completed |
| hard_bits | output | 64 | Decoded bits, row-major in original orientation |

## Verification
Two things can happen in the same clock: the last decoding step, which writes the result and raises `done`, and a new `start` arriving at the input. The bench raises `start`, with different samples, exactly on the clock of the last step, and also once in the middle of a run. A correct block finishes the original decode on time with the original answer, and `done` then stays high, which shows the late pulse did not restart it. Every other array is judged against a step-by-step model of the algorithm held in the bench, and noiseless codewords are judged against the encoder output directly.

// File: rtl/tpd_pkg.sv
package tpd_pkg;
    localparam int DIM = 8;   // array side and component code length
    localparam int SW  = 5;   // soft sample width
    localparam int XW  = 7;   // extrinsic / sum width
    localparam int BW  = 4;   // beta width
    localparam int MW  = 9;   // path metric width

    typedef logic signed [SW-1:0] samp_t;
    typedef logic signed [XW-1:0] xval_t;
    typedef samp_t [DIM-1:0]      srow_t;
    typedef xval_t [DIM-1:0]      xrow_t;
    typedef srow_t [DIM-1:0]      smat_t;
    typedef xrow_t [DIM-1:0]      xmat_t;
    typedef logic  [DIM-1:0]      brow_t;
    typedef brow_t [DIM-1:0]      bmat_t;

    localparam xval_t SAMP_HI = xval_t'((1 << (SW-1)) - 1);
    localparam xval_t SAMP_LO = xval_t'(-(1 << (SW-1)));

    function automatic samp_t sat_samp(input xval_t v);
        xval_t t;
        if (v > SAMP_HI)      t = SAMP_HI;
        else if (v < SAMP_LO) t = SAMP_LO;
        else                  t = v;
        return t[SW-1:0];
    endfunction

    function automatic smat_t flip_s(input smat_t m);
        smat_t o;
        for (int a = 0; a < DIM; a++)
            for (int b = 0; b < DIM; b++)
                o[a][b] = m[b][a];
        return o;
    endfunction

    function automatic xmat_t flip_x(input xmat_t m);
        xmat_t o;
        for (int a = 0; a < DIM; a++)
            for (int b = 0; b < DIM; b++)
                o[a][b] = m[b][a];
        return o;
    endfunction

    function automatic bmat_t flip_b(input bmat_t m);
        bmat_t o;
        for (int a = 0; a < DIM; a++)
            for (int b = 0; b < DIM; b++)
                o[a][b] = m[b][a];
        return o;
    endfunction
endpackage

// File: rtl/tpd_wagner.sv
module tpd_wagner
    import tpd_pkg::*;
(
    input  srow_t e_row,
    output brow_t bits_o
);
    localparam int PAIRS = DIM / 2;
    localparam int PW    = $clog2(PAIRS);

    typedef logic [MW-1:0] met_t;
    typedef struct packed {
        logic [PAIRS-1:0] sel;
        met_t             total;
    } fam_t;

    function automatic met_t cost_zero(input samp_t s);
        return met_t'(int'(s) + 16);
    endfunction

    function automatic met_t cost_one(input samp_t s);
        return met_t'(15 - int'(s));
    endfunction

    // best word of one family: fam=0 pairs {00,11}, fam=1 pairs {01,10}
    function automatic fam_t decode_family(input srow_t e, input logic fam);
        fam_t          res;
        met_t          c0, c1, gap, best_gap;
        logic [PW-1:0] pick;
        res.total = '0;
        res.sel   = '0;
        best_gap  = '1;
        pick      = '0;
        for (int p = 0; p < PAIRS; p++) begin
            c0 = cost_zero(e[2*p]) + (fam ? cost_one(e[2*p+1])  : cost_zero(e[2*p+1]));
            c1 = cost_one(e[2*p])  + (fam ? cost_zero(e[2*p+1]) : cost_one(e[2*p+1]));
            res.sel[p] = (c1 < c0);
            gap        = res.sel[p] ? (c0 - c1) : (c1 - c0);
            res.total  = res.total + (res.sel[p] ? c1 : c0);
            if (gap < best_gap) begin
                best_gap = gap;
                pick     = PW'(p);
            end
        end
        if (^res.sel) begin
            res.sel[pick] = ~res.sel[pick];
            res.total     = res.total + best_gap;
        end
        return res;
    endfunction

    fam_t fam_a, fam_b;
    logic use_b;

    always_comb begin
        fam_a = decode_family(e_row, 1'b0);
        fam_b = decode_family(e_row, 1'b1);
        use_b = (fam_b.total < fam_a.total);
        for (int p = 0; p < PAIRS; p++) begin
            bits_o[2*p]   = use_b ? fam_b.sel[p] : fam_a.sel[p];
            bits_o[2*p+1] = use_b ? ~fam_b.sel[p] : fam_a.sel[p];
        end
    end
endmodule

// File: rtl/tpd_siso_row.sv
module tpd_siso_row
    import tpd_pkg::*;
(
    input  srow_t          r_row,
    input  xrow_t          x_row,
    input  logic [BW-1:0]  beta,
    output brow_t          bits_o,
    output xrow_t          ext_o
);
    srow_t e_row;
    brow_t hard;

    always_comb begin
        for (int i = 0; i < DIM; i++) begin
            e_row[i] = sat_samp(xval_t'(samp_t'(r_row[i])) + xval_t'(x_row[i]));
        end
    end

    tpd_wagner u_wagner (
        .e_row  (e_row),
        .bits_o (hard)
    );

    always_comb begin
        xval_t soft_v;
        xval_t ie_v;
        for (int i = 0; i < DIM; i++) begin
            soft_v   = hard[i] ? xval_t'(beta) : -xval_t'(beta);
            ie_v     = soft_v - xval_t'(samp_t'(e_row[i]));
            ext_o[i] = ie_v >>> 2;
        end
    end

    assign bits_o = hard;
endmodule

// File: rtl/tpd_iter_top.sv
module tpd_iter_top
    import tpd_pkg::*;
#(
    parameter int ITERS = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [DIM*DIM*SW-1:0]  rx_soft,
    output logic                   done,
    output logic [DIM*DIM-1:0]     hard_bits
);
    localparam int STEPS    = 2 * ITERS;
    localparam int STW      = $clog2(STEPS + 1);
    localparam bit FLIP_OUT = (STEPS % 2) == 0;
    localparam int BMAX     = (1 << BW) - 1;
    localparam xval_t EXT_HI = xval_t'(7);
    localparam xval_t EXT_LO = xval_t'(-8);

    typedef struct packed {
        logic           run;
        logic [STW-1:0] step;
        smat_t          r;
        xmat_t          x;
        logic           done;
        bmat_t          hard;
    } state_t;

    state_t        st_d, st_q;
    logic [BW-1:0] beta;
    smat_t         rx_mat;
    bmat_t         row_bits;
    xmat_t         row_ext;

    assign rx_mat = rx_soft;

    // beta grows by four per step, saturating at the width limit
    always_comb begin
        int bi;
        bi = 4 * int'(st_q.step) - 1;
        if (bi > BMAX)   beta = BW'(BMAX);
        else if (bi < 0) beta = '0;
        else             beta = BW'(bi);
    end

    for (genvar g = 0; g < DIM; g++) begin : g_row
        tpd_siso_row u_row (
            .r_row  (st_q.r[g]),
            .x_row  (st_q.x[g]),
            .beta   (beta),
            .bits_o (row_bits[g]),
            .ext_o  (row_ext[g])
        );
    end

    always_comb begin
        st_d = st_q;
        if (st_q.run) begin
            st_d.r = flip_s(st_q.r);
            st_d.x = flip_x(row_ext);
            if (st_q.step == STW'(STEPS)) begin
                st_d.run  = 1'b0;
                st_d.step = '0;
                st_d.done = 1'b1;
                st_d.hard = FLIP_OUT ? flip_b(row_bits) : row_bits;
            end else begin
                st_d.step = st_q.step + 1'b1;
            end
        end else if (start) begin
            st_d.run  = 1'b1;
            st_d.step = STW'(1);
            st_d.r    = rx_mat;
            st_d.x    = '0;
            st_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done      = st_q.done;
    assign hard_bits = st_q.hard;

    // observation flags for the checks below
    logic ext_in_range;
    logic rows_are_cw;
    always_comb begin
        logic par;
        ext_in_range = 1'b1;
        rows_are_cw  = 1'b1;
        for (int a = 0; a < DIM; a++) begin
            par = 1'b0;
            for (int b = 0; b < DIM; b++) begin
                if (xval_t'(row_ext[a][b]) > EXT_HI || xval_t'(row_ext[a][b]) < EXT_LO)
                    ext_in_range = 1'b0;
            end
            for (int p = 0; p < DIM/2; p++) begin
                if ((row_bits[a][2*p] ^ row_bits[a][2*p+1]) != (row_bits[a][0] ^ row_bits[a][1]))
                    rows_are_cw = 1'b0;
                par = par ^ row_bits[a][2*p];
            end
            if (par) rows_are_cw = 1'b0;
        end
    end

    p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !st_q.run) |=> (st_q.run && !done && st_q.step == STW'(1)));

    p_done_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(st_q.step) == STW'(STEPS)));

    p_step_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |-> (st_q.step != '0 && st_q.step <= STW'(STEPS)));

    p_codeword_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |-> rows_are_cw);

    p_ext_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |-> ext_in_range);

    p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && start && st_q.step != STW'(STEPS))
            |=> (st_q.run && st_q.step == $past(st_q.step) + 1'b1));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run && !start) |=> ($stable(hard_bits) && $stable(done)));
endmodule

// File: tb/test_tpd_iter_top.sv
module test_tpd_iter_top;
    localparam int ITERS = 2;
    localparam int STEPS = 2 * ITERS;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [319:0] rx_soft = '0;
    logic         done;
    logic [63:0]  hard_bits;

    always #4 clk = ~clk;   // 125 MHz

    tpd_iter_top #(.ITERS(ITERS)) i_tpd_iter_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .rx_soft   (rx_soft),
        .done      (done),
        .hard_bits (hard_bits)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit ended = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        logic [63:0] exp;
        int          t0;
        string       tag;
    } item_t;
    item_t sb[$];

    task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    function automatic int clamp5(input int v);
        if (v > 15) return 15;
        if (v < -16) return -16;
        return v;
    endfunction

    function automatic int quarter_floor(input int v);
        if (v >= 0) return v / 4;
        return -((-v + 3) / 4);
    endfunction

    function automatic int cost(input bit b, input int v);
        return b ? (15 - v) : (v + 16);
    endfunction

    task automatic ref_row(input int e[8], output logic [7:0] b);
        int         tot[2];
        logic [3:0] s[2];
        for (int k = 0; k < 2; k++) begin
            int best;
            int at;
            best = 1000;
            at = 0;
            tot[k] = 0;
            s[k] = '0;
            for (int p = 0; p < 4; p++) begin
                int c0;
                int c1;
                int g;
                c0 = cost(1'b0, e[2*p]) + cost(k[0], e[2*p+1]);
                c1 = cost(1'b1, e[2*p]) + cost(!k[0], e[2*p+1]);
                s[k][p] = (c1 < c0);
                tot[k] += s[k][p] ? c1 : c0;
                g = (c1 > c0) ? (c1 - c0) : (c0 - c1);
                if (g < best) begin
                    best = g;
                    at = p;
                end
            end
            if (^s[k]) begin
                s[k][at] = ~s[k][at];
                tot[k] += best;
            end
        end
        for (int p = 0; p < 4; p++) begin
            if (tot[1] < tot[0]) begin
                b[2*p] = s[1][p];
                b[2*p+1] = ~s[1][p];
            end else begin
                b[2*p] = s[0][p];
                b[2*p+1] = s[0][p];
            end
        end
    endtask

    task automatic ref_decode(input logic [319:0] v, output logic [63:0] res);
        int         r[8][8];
        int         x[8][8];
        int         nr[8][8];
        int         nx[8][8];
        int         e[8];
        logic [7:0] b;
        logic [7:0] hb[8];
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++) begin
                r[i][j] = int'($signed(v[(i*8+j)*5 +: 5]));
                x[i][j] = 0;
            end
        for (int j = 1; j <= STEPS; j++) begin
            int beta;
            beta = (4*j - 1 > 15) ? 15 : 4*j - 1;
            for (int i = 0; i < 8; i++) begin
                for (int c = 0; c < 8; c++) e[c] = clamp5(r[i][c] + x[i][c]);
                ref_row(e, b);
                hb[i] = b;
                for (int c = 0; c < 8; c++) begin
                    nx[c][i] = quarter_floor((b[c] ? beta : -beta) - e[c]);
                    nr[c][i] = r[i][c];
                end
            end
            x = nx;
            r = nr;
        end
        for (int i = 0; i < 8; i++)
            for (int c = 0; c < 8; c++)
                res[i*8+c] = ((STEPS - 1) % 2 == 1) ? hb[c][i] : hb[i][c];
    endtask

    // ---------------- encoder and channel ----------------
    function automatic logic [7:0] enc_row(input logic [3:0] u);
        logic [3:0] s;
        logic [7:0] w;
        s = {u[1] ^ u[2] ^ u[3], u[3:1]};
        for (int p = 0; p < 4; p++) begin
            w[2*p] = s[p];
            w[2*p+1] = s[p] ^ u[0];
        end
        return w;
    endfunction

    function automatic logic [63:0] enc_product(input logic [15:0] info);
        logic [7:0]  rows[4];
        logic [63:0] cw;
        for (int i = 0; i < 4; i++) rows[i] = enc_row(info[4*i +: 4]);
        for (int c = 0; c < 8; c++) begin
            logic [7:0] col;
            col = enc_row({rows[3][c], rows[2][c], rows[1][c], rows[0][c]});
            for (int r = 0; r < 8; r++) cw[r*8+c] = col[r];
        end
        return cw;
    endfunction

    function automatic logic [319:0] modulate(input logic [63:0] cw, input int amp, input int noise);
        logic [319:0] v;
        for (int k = 0; k < 64; k++) begin
            int s;
            s = cw[k] ? amp : -amp;
            if (noise > 0) s += int'($urandom_range(2*noise)) - noise;
            s = clamp5(s);
            v[k*5 +: 5] = 5'(s);
        end
        return v;
    endfunction

    // ---------------- driver ----------------
    task automatic run_vec(input logic [319:0] v, input logic [63:0] exp, input string tag, input int poke);
        item_t it;
        logic [63:0] held;
        @(negedge clk);
        rx_soft = v;
        start = 1'b1;
        it.exp = exp;
        it.t0 = cyc;
        it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R9 done falls after start", 64'(done), 64'd0);
        if (poke > 0) begin
            repeat (poke) @(negedge clk);
            rx_soft = ~v;
            start = 1'b1;   // R8: must be ignored
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        held = hard_bits;
        repeat (3) @(negedge clk);
        check(done == 1'b1 && hard_bits == held, {"R9 hold after ", tag}, hard_bits, held);
    endtask

    // ---------------- monitor ----------------
    logic prev_done = 1'b0;
    always @(negedge clk) begin
        if (rst_n && done && !prev_done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R2 done without pending decode", 64'(done), 64'd0);
            end else begin
                item_t it;
                it = sb.pop_front();
                check(hard_bits == it.exp, it.tag, hard_bits, it.exp);
                check(cyc - it.t0 == STEPS + 1, "R2 latency", 64'(cyc - it.t0), 64'(STEPS + 1));
            end
        end
        prev_done <= done;
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R2 watchdog: done never reached, actual=0 expected=1");
        finish_run();
    end

    initial begin
        logic [63:0] cw;
        logic [63:0] exp;
        logic [319:0] v;
        repeat (3) @(negedge clk);
        check(done == 1'b0 && hard_bits == '0, "R10 reset state", hard_bits, 64'd0);
        rst_n = 1'b1;

        // R7 and R1/R6: noiseless codewords, compared with the encoder output
        run_vec(modulate(enc_product(16'h0000), 12, 0), enc_product(16'h0000), "R7 zero word", 0);
        run_vec(modulate(enc_product(16'hFFFF), 12, 0), enc_product(16'hFFFF), "R7 all-ones info", 0);
        run_vec(modulate(enc_product(16'h0001), 12, 0), enc_product(16'h0001), "R6 asymmetric word", 0);
        for (int n = 0; n < 5; n++) begin
            cw = enc_product(16'($urandom));
            run_vec(modulate(cw, 12, 0), cw, "R7 R1 noiseless random", 0);
        end

        // R3 R4 R5 R6: noisy arrays against the step model
        for (int n = 0; n < 40; n++) begin
            cw = enc_product(16'($urandom));
            v = modulate(cw, (n % 3 == 0) ? 3 : 6, 7);
            ref_decode(v, exp);
            run_vec(v, exp, "R3/R4/R5/R6 noisy vs model", 0);
        end

        // R5 saturation: large magnitudes with sign noise
        for (int n = 0; n < 6; n++) begin
            cw = enc_product(16'($urandom));
            v = modulate(cw, 14, 16);
            ref_decode(v, exp);
            run_vec(v, exp, "R5 clamped inputs vs model", 0);
        end

        // R8: start mid-run and on the last step
        cw = enc_product(16'h5A3C);
        v = modulate(cw, 5, 6);
        ref_decode(v, exp);
        run_vec(v, exp, "R8 start mid-run ignored", 1);
        run_vec(v, exp, "R8 start on last step ignored", 3);

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R2 all results produced", 64'(sb.size()), 64'd0);
        finish_run();
    end
endmodule